// File: doc/BRIEF.md
# Byte Insert Execution Unit

This unit carries out the byte-insert operations of a 64-bit integer pipeline. One datapath serves seven function codes. Each code picks a byte mask. The mask keeps the low one, two, four or eight bytes of the A operand and clears the rest. The kept bytes are then moved to a byte offset inside a quadword.

The low-half codes move the bytes up by the offset. The high-half codes return the bytes that spill out above the top of the quadword. The offset is the low three bits of either a full B register value or an 8-bit literal, and a literal-select flag chooses between them.

An issue strobe samples the inputs. One clock later the unit presents a registered result, a write-enable and the destination index, with valid high for that single cycle. Register index 31 is the hard-wired zero register:
- As the A source, it makes A read as zero.
- As the destination, it suppresses write-back.

An unknown function code returns zero and raises an illegal-operation flag.

Top module: `ins_unit`

## Requirements
- R1: The function code selects the kept bytes of A, where mask bit n keeps byte n (bits 8n+7..8n) and a clear bit zeroes that byte. The codes and masks are 0x0B→0x01, 0x1B→0x03, 0x2B→0x0F, 0x3B→0xFF, 0x57→0x03, 0x67→0x0F and 0x77→0xFF.
- R2: For codes 0x0B, 0x1B, 0x2B and 0x3B the result is the masked A shifted left by 8·k bits with zero fill, where k is the 3-bit offset.
- R3: For codes 0x57, 0x67 and 0x77 the result is the masked A shifted right by 64−8·k bits with zero fill. When k = 0 the result is all zeros.
- R4: When lit_sel_i is 1, k is lit_i[2:0] and b_i is ignored. When lit_sel_i is 0, k is b_i[2:0] and lit_i is ignored.
- R5: When ra_idx_i is 31, A reads as zero and the result is zero.
- R6: wr_en_o is 1 in the result cycle of a legal operation whose destination index is not 31. It is 0 when the destination index is 31, and 0 in every cycle without a result.
- R7: Any other function code gives result 0, illegal_o = 1 and wr_en_o = 0 in the result cycle.
- R8: valid_o is 1 in exactly the cycle after a cycle with issue_i = 1, and 0 otherwise. In that cycle rc_idx_o holds the destination index that was issued.
- R9: While rst_ni is low, valid_o, wr_en_o, illegal_o and result_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Issue strobe; inputs are sampled when high |
| func_i | input | 7 | Function code |
| a_i | input | 64 | A operand value |
| b_i | input | 64 | B register value |
| lit_i | input | 8 | Literal B operand |
| lit_sel_i | input | 1 | 1 selects lit_i as the offset source |
| ra_idx_i | input | 5 | A source register index |
| rc_idx_i | input | 5 | Destination register index |
| valid_o | output | 1 | Result valid pulse |
| wr_en_o | output | 1 | Write-back enable |
| illegal_o | output | 1 | Unknown function code flag |
| rc_idx_o | output | 5 | Registered destination index |
| result_o | output | 64 | Registered result |

## Verification
The assertions assume that issue_i, func_i and the index inputs are stable and known at each rising edge after reset. They also assume that every issued operation is independent, since the unit holds no state between operations. The stimulus changes inputs only on falling edges and pulses issue for one cycle per operation. It sweeps all 128 function codes, all eight offsets and three A patterns. For each operation it puts a conflicting offset on the unused B source, so that a wrong source select shows up in the result.

// File: rtl/ins_pkg.sv
package ins_pkg;
  localparam int unsigned FUNC_W = 7;
  localparam int unsigned IDX_W  = 5;
  localparam logic [IDX_W-1:0] ZERO_REG = 5'd31;

  typedef enum logic [FUNC_W-1:0] {
    OP_LO_B = 7'h0B,
    OP_LO_W = 7'h1B,
    OP_LO_L = 7'h2B,
    OP_LO_Q = 7'h3B,
    OP_HI_W = 7'h57,
    OP_HI_L = 7'h67,
    OP_HI_Q = 7'h77
  } ins_op_e;
endpackage

// File: rtl/ins_decode.sv
module ins_decode
  import ins_pkg::*;
#(
  parameter int unsigned BYTES = 8
) (
  input  logic [FUNC_W-1:0] func_i,
  output logic              legal_o,
  output logic              high_o,
  output logic [BYTES-1:0]  mask_o
);
  localparam int unsigned CNT_W = $clog2(BYTES + 1);

  logic [CNT_W-1:0] lanes;

  always_comb begin
    legal_o = 1'b1;
    high_o  = 1'b0;
    lanes   = '0;
    case (func_i)
      OP_LO_B: lanes = CNT_W'(1);
      OP_LO_W: lanes = CNT_W'(2);
      OP_LO_L: lanes = CNT_W'(4);
      OP_LO_Q: lanes = CNT_W'(BYTES);
      OP_HI_W: begin lanes = CNT_W'(2); high_o = 1'b1; end
      OP_HI_L: begin lanes = CNT_W'(4); high_o = 1'b1; end
      OP_HI_Q: begin lanes = CNT_W'(BYTES); high_o = 1'b1; end
      default: legal_o = 1'b0;
    endcase
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_mask
    assign mask_o[g] = (CNT_W'(g) < lanes);
  end
endmodule

// File: rtl/ins_lane_mask.sv
module ins_lane_mask #(
  parameter int unsigned BYTES = 8
) (
  input  logic [BYTES*8-1:0] data_i,
  input  logic [BYTES-1:0]   keep_i,
  output logic [BYTES*8-1:0] data_o
);
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign data_o[g*8 +: 8] = keep_i[g] ? data_i[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/ins_shifter.sv
module ins_shifter #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned OFF_W = $clog2(DATA_W / 8),
  localparam int unsigned SH_W  = OFF_W + 3
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              high_i,
  output logic [DATA_W-1:0] data_o
);
  logic [SH_W-1:0]   bit_off;
  logic [SH_W-1:0]   inv_off;
  logic [DATA_W-1:0] lo_res;
  logic [DATA_W-1:0] hi_part;
  logic [DATA_W-1:0] hi_res;

  assign bit_off = {off_i, 3'b000};
  // ones-complement gives (W - 8k - 1); the fixed extra shift of 1 reaches W at k = 0
  assign inv_off = ~bit_off;
  assign lo_res  = data_i << bit_off;
  assign hi_part = data_i >> inv_off;
  assign hi_res  = hi_part >> 1;
  assign data_o  = high_i ? hi_res : lo_res;
endmodule

// File: rtl/ins_unit.sv
module ins_unit
  import ins_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LIT_W  = 8,
  localparam int unsigned BYTES = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [6:0]        func_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [LIT_W-1:0]  lit_i,
  input  logic              lit_sel_i,
  input  logic [4:0]        ra_idx_i,
  input  logic [4:0]        rc_idx_i,
  output logic              valid_o,
  output logic              wr_en_o,
  output logic              illegal_o,
  output logic [4:0]        rc_idx_o,
  output logic [DATA_W-1:0] result_o
);
  logic              legal;
  logic              high;
  logic [BYTES-1:0]  mask;
  logic [DATA_W-1:0] a_eff;
  logic [DATA_W-1:0] a_kept;
  logic [DATA_W-1:0] shifted;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] res_d;
  logic              unused_hi_bits;

  assign unused_hi_bits = ^{b_i[DATA_W-1:OFF_W], lit_i[LIT_W-1:OFF_W]};

  ins_decode #(.BYTES(BYTES)) u_decode (
    .func_i (func_i),
    .legal_o(legal),
    .high_o (high),
    .mask_o (mask)
  );

  assign a_eff = (ra_idx_i == ZERO_REG) ? '0 : a_i;
  assign off   = lit_sel_i ? lit_i[OFF_W-1:0] : b_i[OFF_W-1:0];

  ins_lane_mask #(.BYTES(BYTES)) u_lane_mask (
    .data_i(a_eff),
    .keep_i(mask),
    .data_o(a_kept)
  );

  ins_shifter #(.DATA_W(DATA_W)) u_shifter (
    .data_i(a_kept),
    .off_i (off),
    .high_i(high),
    .data_o(shifted)
  );

  assign res_d = legal ? shifted : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      rc_idx_o  <= '0;
      result_o  <= '0;
    end else begin
      valid_o   <= issue_i;
      wr_en_o   <= issue_i && legal && (rc_idx_i != ZERO_REG);
      illegal_o <= issue_i && !legal;
      if (issue_i) begin
        rc_idx_o <= rc_idx_i;
        result_o <= res_d;
      end
    end
  end

  assert_mask_shape_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal |-> (mask[0] && ((mask & (mask + 1'b1)) == '0)));

  assert_hi_zero_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && high && off == '0) |=> (result_o == '0));

  assert_zero_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && ra_idx_i == ZERO_REG) |=> (result_o == '0));

  assert_no_wr_zero_dst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && rc_idx_o == ZERO_REG) |-> !wr_en_o);

  assert_wr_needs_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> valid_o);

  assert_illegal_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (valid_o && !wr_en_o && result_o == '0));

  assert_valid_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> (valid_o && rc_idx_o == $past(rc_idx_i)));

  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> !valid_o);
endmodule

// File: tb/ins_unit_bench.sv
module ins_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_i = 1'b0;
  logic [6:0]  func_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [7:0]  lit_i = '0;
  logic        lit_sel_i = 1'b0;
  logic [4:0]  ra_idx_i = '0;
  logic [4:0]  rc_idx_i = '0;
  logic        valid_o, wr_en_o, illegal_o;
  logic [4:0]  rc_idx_o;
  logic [63:0] result_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  ins_unit u_ins_unit (
    .clk_i, .rst_ni, .issue_i, .func_i, .a_i, .b_i, .lit_i, .lit_sel_i,
    .ra_idx_i, .rc_idx_i, .valid_o, .wr_en_o, .illegal_o, .rc_idx_o, .result_o
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input logic [6:0] f);
    case (f)
      7'h0B: return 8'h01;
      7'h1B: return 8'h03;
      7'h2B: return 8'h0F;
      7'h3B: return 8'hFF;
      7'h57: return 8'h03;
      7'h67: return 8'h0F;
      7'h77: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit is_legal(input logic [6:0] f);
    return f == 7'h0B || f == 7'h1B || f == 7'h2B || f == 7'h3B ||
           f == 7'h57 || f == 7'h67 || f == 7'h77;
  endfunction

  function automatic logic [63:0] model(input logic [6:0] f, input logic [63:0] a,
                                        input int k, input bit ra_zero);
    logic [63:0] kept;
    logic [7:0]  m;
    if (!is_legal(f) || ra_zero) return 64'h0;
    m = mask_of(f);
    kept = '0;
    for (int i = 0; i < 8; i++) if (m[i]) kept[i*8 +: 8] = a[i*8 +: 8];
    if (f[6]) return (k == 0) ? 64'h0 : (kept >> (64 - 8 * k));
    return kept << (8 * k);
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] pats [3];
    pats[0] = 64'h0123456789ABCDEF;
    pats[1] = 64'hFFFFFFFFFFFFFFFF;
    pats[2] = 64'hF1E2D3C4B5A69788;

    repeat (3) @(negedge clk_i);
    check("R9 valid in reset", 64'(valid_o), 64'h0);
    check("R9 wr_en in reset", 64'(wr_en_o), 64'h0);
    check("R9 illegal in reset", 64'(illegal_o), 64'h0);
    check("R9 result in reset", result_o, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 no valid without issue", 64'(valid_o), 64'h0);

    for (int f = 0; f < 128; f++) begin
      for (int k = 0; k < 8; k++) begin
        for (int p = 0; p < 3; p++) begin
          bit lit_mode, ra_zero, rc_zero;
          string tag;
          logic [63:0] exp;
          lit_mode = ((k + p + f) % 2) == 1;
          ra_zero  = (p == 2 && k == 3);
          rc_zero  = (p == 1 && k == 5);
          func_i    = 7'(f);
          a_i       = pats[p] ^ {8{8'(f)}};
          lit_sel_i = lit_mode;
          // the unused source carries a different offset
          lit_i     = lit_mode ? {5'h15, 3'(k)} : {5'h0A, 3'(k + 3)};
          b_i       = lit_mode ? {61'h1234_5678_9ABC_DEF, 3'(k + 5)}
                               : {61'h0FED_CBA9_8765_432, 3'(k)};
          ra_idx_i  = ra_zero ? 5'd31 : 5'(p + 1);
          rc_idx_i  = rc_zero ? 5'd31 : 5'(k + 4);
          issue_i   = 1'b1;
          @(negedge clk_i);
          issue_i = 1'b0;
          exp = model(7'(f), a_i, k, ra_zero);
          if (!is_legal(7'(f)))   tag = "R7 result";
          else if (ra_zero)       tag = "R5 result";
          else if (lit_mode)      tag = f[6] ? "R1/R3/R4 result" : "R1/R2/R4 result";
          else                    tag = f[6] ? "R1/R3 result" : "R1/R2 result";
          check(tag, result_o, exp);
          check("R8 valid", 64'(valid_o), 64'h1);
          check("R8 rc_idx", 64'(rc_idx_o), 64'(rc_idx_i));
          check("R7 illegal", 64'(illegal_o), 64'(!is_legal(7'(f))));
          check("R6 wr_en", 64'(wr_en_o), 64'(is_legal(7'(f)) && !rc_zero));
          @(negedge clk_i);
          check("R8 valid drops", 64'(valid_o), 64'h0);
          check("R6 wr_en drops", 64'(wr_en_o), 64'h0);
        end
      end
    end

    func_i = 7'h3B; a_i = 64'hA5A5A5A5A5A5A5A5; lit_sel_i = 1'b1; lit_i = 8'h01;
    ra_idx_i = 5'd2; rc_idx_i = 5'd7; issue_i = 1'b1;
    @(negedge clk_i);
    issue_i = 1'b0;
    check("R2 pre-reset result", result_o, 64'hA5A5A5A5A5A5A500);
    #1 rst_ni = 1'b0;
    #1;
    check("R9 valid cleared", 64'(valid_o), 64'h0);
    check("R9 wr_en cleared", 64'(wr_en_o), 64'h0);
    check("R9 result cleared", result_o, 64'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule